// File: doc/BRIEF.md
# Overcurrent Trip Latch with Recovery

This block sits between the current comparators of a battery-pack protector and the drive for its series switch pair. Two comparator flags arrive, one for charge current above its limit and one for discharge current above its limit. Each flag has its own qualification counter. The counter advances on an internal millisecond-style tick and is cleared whenever its flag drops. A surge that does not span the configured number of ticks is ignored. A single qualified event latches the fault. The latched fault asks for the switches to open, turns on a bypass path across them, and reports which direction caused the trip.

Once latched, the fault stays until a recovery event arrives. A rising-edge pulse on the enable input clears it at any time. While the bypass is active, a flag reporting a very high terminal impedance also clears it. That flag means the load seen through the bypass has become megohm-range. Taking enable low while the fault is latched removes the bypass. Because that also removes the means of detecting a high-impedance load, only an enable edge can clear the fault from then on. With enable low the switch-off request is held asserted and no trip can qualify.

Top module: `ocp_trip_guard`

## Requirements
- R1: During and right after reset, `fault_o` = 0, `bypass_en_o` = 0, `trip_dir_o` = 2'b00 and `gate_off_o` = 1.
- R2: A direction flag held high while QUAL_TICKS internal ticks occur latches the fault. A tick occurs once every TICK_DIV clock cycles. A flag that stays high for fewer ticks leaves the fault clear.
- R3: The qualification count of a direction is cleared by any cycle in which its flag is low, so two short surges separated by one low cycle do not add up.
- R4: Charge and discharge have separate counters, and either one alone can trip. `trip_dir_o` reads 2'b01 for a charge trip and 2'b10 for a discharge trip. If both qualify in the same cycle, the value is 2'b01.
- R5: When both flags are high, the direction whose count completes first is recorded in `trip_dir_o`.
- R6: While the fault is latched, `fault_o` = 1 and `gate_off_o` = 1, and `trip_dir_o` holds its value. With no recovery event, the fault stays latched.
- R7: An `en_rise_i` pulse during a latched fault clears it on the next clock edge. `trip_dir_o` returns to 2'b00, `bypass_en_o` to 0, and `gate_off_o` to 0 when enable is high.
- R8: `hiz_load_i` high while `bypass_en_o` = 1 clears the fault on the next clock edge.
- R9: `en_level_i` low during a latched fault drops `bypass_en_o` and keeps `fault_o` = 1. After that, `hiz_load_i` no longer clears the fault.
- R10: While `en_level_i` is low, `gate_off_o` = 1 and the counters are held clear, so no trip can occur however long a flag stays high.
- R11: The counters are held clear while the fault is latched. After a recovery, a flag that is still high needs a full QUAL_TICKS ticks again before it can trip.
- R12: The bypass is enabled on the edge that latches the fault, and only when enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_over_i | input | 1 | Charge current above limit |
| dis_over_i | input | 1 | Discharge current above limit |
| hiz_load_i | input | 1 | Very high terminal impedance seen through the bypass |
| en_level_i | input | 1 | Enable level |
| en_rise_i | input | 1 | One-cycle pulse on an enable rising edge |
| gate_off_o | output | 1 | Request to open the switch pair |
| bypass_en_o | output | 1 | Bypass path enable |
| fault_o | output | 1 | Overcurrent fault latched |
| trip_dir_o | output | 2 | Tripping direction, 01 charge, 10 discharge, 00 none |

## Verification
The assertions assume that `en_rise_i` is a one-cycle pulse raised only in a cycle where `en_level_i` is high. They also assume that all inputs are synchronous to `clk`. The stimulus drives every input on the falling clock edge. It pulses `en_rise_i` only together with or after a high enable level. It holds flag windows for whole multiples of the tick period, so the number of ticks in each window is known whatever the tick phase. Under these conditions the bypass can only exist while a fault is latched, and a fault can only rise after a current flag was high.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_ARMED     = 2'd0,
    ST_TRIP_BYP  = 2'd1,
    ST_TRIP_HOLD = 2'd2
  } ocp_state_e;

  typedef logic [1:0] ocp_dir_t;

  localparam ocp_dir_t DIR_NONE = 2'b00;
  localparam ocp_dir_t DIR_CHG  = 2'b01;
  localparam ocp_dir_t DIR_DIS  = 2'b10;

  localparam int NUM_DIRS = 2;
endpackage

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
  parameter int TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ocp_qual_filter.sv
module ocp_qual_filter #(
  parameter int QUAL_TICKS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  input  logic flag,
  output logic qual
);
  localparam int CNT_W = $clog2(QUAL_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_TICKS - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(QUAL_TICKS);

  logic [CNT_W-1:0] cnt_q;

  // The tick that completes the count raises qual in the same cycle
  assign qual = flag && tick && !clear && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || !flag) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_DIRS-1:0] qual,
  input  logic                en_level,
  input  logic                en_rise,
  input  logic                hiz_load,
  output logic                fault,
  output logic                bypass_en,
  output logic                gate_off,
  output ocp_dir_t            dir
);
  ocp_state_e st_q, st_d;
  ocp_dir_t   dir_d;

  always_comb begin
    st_d  = st_q;
    dir_d = dir;
    case (st_q)
      ST_ARMED: begin
        if (en_level && (qual != '0)) begin
          st_d  = ST_TRIP_BYP;
          dir_d = qual[0] ? DIR_CHG : DIR_DIS;   // charge wins a tie
        end
      end
      ST_TRIP_BYP: begin
        if (en_rise || hiz_load) begin
          st_d  = ST_ARMED;
          dir_d = DIR_NONE;
        end else if (!en_level) begin
          st_d  = ST_TRIP_HOLD;
        end
      end
      ST_TRIP_HOLD: begin
        if (en_rise) begin
          st_d  = ST_ARMED;
          dir_d = DIR_NONE;
        end
      end
      default: begin
        st_d  = ST_ARMED;
        dir_d = DIR_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_ARMED;
      dir       <= DIR_NONE;
      fault     <= 1'b0;
      bypass_en <= 1'b0;
      gate_off  <= 1'b1;
    end else begin
      st_q      <= st_d;
      dir       <= dir_d;
      fault     <= (st_d != ST_ARMED);
      bypass_en <= (st_d == ST_TRIP_BYP);
      gate_off  <= (st_d != ST_ARMED) || !en_level;
    end
  end
endmodule

// File: rtl/ocp_trip_guard.sv
module ocp_trip_guard
  import ocp_pkg::*;
#(
  parameter int TICK_DIV   = 250000,
  parameter int QUAL_TICKS = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chg_over_i,
  input  logic       dis_over_i,
  input  logic       hiz_load_i,
  input  logic       en_level_i,
  input  logic       en_rise_i,
  output logic       gate_off_o,
  output logic       bypass_en_o,
  output logic       fault_o,
  output logic [1:0] trip_dir_o
);
  logic                tick;
  logic [NUM_DIRS-1:0] flags;
  logic [NUM_DIRS-1:0] qual;
  logic                cnt_clear;

  assign flags     = {dis_over_i, chg_over_i};
  assign cnt_clear = fault_o || !en_level_i;

  ocp_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    ocp_qual_filter #(.QUAL_TICKS(QUAL_TICKS)) filt_i (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .clear (cnt_clear),
      .flag  (flags[d]),
      .qual  (qual[d])
    );
  end

  ocp_fault_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .qual      (qual),
    .en_level  (en_level_i),
    .en_rise   (en_rise_i),
    .hiz_load  (hiz_load_i),
    .fault     (fault_o),
    .bypass_en (bypass_en_o),
    .gate_off  (gate_off_o),
    .dir       (trip_dir_o)
  );
endmodule

// File: rtl/ocp_trip_guard_chk.sv
module ocp_trip_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       chg_over_i,
  input logic       dis_over_i,
  input logic       hiz_load_i,
  input logic       en_level_i,
  input logic       en_rise_i,
  input logic       gate_off_o,
  input logic       bypass_en_o,
  input logic       fault_o,
  input logic [1:0] trip_dir_o
);
  // R12: bypass only exists with a latched fault
  a_r12_bypass_needs_fault: assert property (@(posedge clk) disable iff (rst)
    bypass_en_o |-> fault_o);

  // R6: a latched fault keeps the switches open and names a direction
  a_r6_fault_gates_off: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (gate_off_o && trip_dir_o != 2'b00));

  // R6: without a recovery event the fault stays
  a_r6_fault_holds: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !en_rise_i && !(hiz_load_i && bypass_en_o)) |=> fault_o);

  // R7: enable edge clears a latched fault
  a_r7_edge_clears: assert property (@(posedge clk) disable iff (rst)
    (fault_o && en_rise_i) |=> (!fault_o && trip_dir_o == 2'b00));

  // R8: high impedance through an active bypass clears the fault
  a_r8_hiz_clears: assert property (@(posedge clk) disable iff (rst)
    (bypass_en_o && hiz_load_i) |=> !fault_o);

  // R9: low enable drops the bypass
  a_r9_low_en_no_bypass: assert property (@(posedge clk) disable iff (rst)
    !en_level_i |=> !bypass_en_o);

  // R10: low enable holds the switch-off request
  a_r10_low_en_gate_off: assert property (@(posedge clk) disable iff (rst)
    !en_level_i |=> gate_off_o);

  // R4: direction code is one-hot or empty
  a_r4_dir_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trip_dir_o));

  // R2: a fault only rises after a current flag was high
  a_r2_trip_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> $past(chg_over_i || dis_over_i));
endmodule

bind ocp_trip_guard ocp_trip_guard_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .chg_over_i  (chg_over_i),
  .dis_over_i  (dis_over_i),
  .hiz_load_i  (hiz_load_i),
  .en_level_i  (en_level_i),
  .en_rise_i   (en_rise_i),
  .gate_off_o  (gate_off_o),
  .bypass_en_o (bypass_en_o),
  .fault_o     (fault_o),
  .trip_dir_o  (trip_dir_o)
);

// File: tb/ocp_trip_guard_tb_top.sv
`timescale 1ns/1ps
module ocp_trip_guard_tb_top;
  localparam int DIV = 3;
  localparam int Q   = 4;

  logic clk = 1'b0;
  logic rst;
  logic chg, dis, hiz, en_lvl, en_rise;
  logic gate_off, bypass_en, fault;
  logic [1:0] dir;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ocp_trip_guard #(.TICK_DIV(DIV), .QUAL_TICKS(Q)) dut_i (
    .clk(clk), .rst(rst),
    .chg_over_i(chg), .dis_over_i(dis), .hiz_load_i(hiz),
    .en_level_i(en_lvl), .en_rise_i(en_rise),
    .gate_off_o(gate_off), .bypass_en_o(bypass_en),
    .fault_o(fault), .trip_dir_o(dir)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rise();
    en_rise = 1'b1;
    cyc(1);
    en_rise = 1'b0;
    cyc(1);
  endtask

  // hold the selected flags for n cycles, then drop them
  task automatic surge(input logic c, input logic d, input int n);
    chg = c; dis = d;
    cyc(n);
    chg = 1'b0; dis = 1'b0;
    cyc(2);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; chg = 0; dis = 0; hiz = 0; en_lvl = 1'b1; en_rise = 0;
    cyc(3);
    chk("R1 fault in reset", fault, 0);
    chk("R1 bypass in reset", bypass_en, 0);
    chk("R1 dir in reset", dir, 0);
    chk("R1 gate_off in reset", gate_off, 1);
    rst = 1'b0;
    cyc(2);
    chk("R1 gate_off after reset, enable high", gate_off, 0);

    // R2/R4/R6: sweep surge length per direction
    for (int d = 0; d < 2; d++) begin
      for (int l = 0; l <= Q + 2; l++) begin
        surge(d == 0, d == 1, l * DIV);
        chk($sformatf("R2 fault dir%0d ticks%0d", d, l), fault, (l >= Q) ? 1 : 0);
        chk($sformatf("R4 dir code dir%0d ticks%0d", d, l), dir,
            (l >= Q) ? ((d == 0) ? 1 : 2) : 0);
        chk($sformatf("R6 gate_off dir%0d ticks%0d", d, l), gate_off, (l >= Q) ? 1 : 0);
        chk($sformatf("R12 bypass dir%0d ticks%0d", d, l), bypass_en, (l >= Q) ? 1 : 0);
        pulse_rise();
        chk($sformatf("R7 cleared dir%0d ticks%0d", d, l), fault, 0);
      end
    end

    // R3: one low cycle between surges restarts the count
    chg = 1'b1; cyc((Q - 1) * DIV);
    chg = 1'b0; cyc(1);
    chg = 1'b1; cyc((Q - 1) * DIV);
    chg = 1'b0; cyc(2);
    chk("R3 split charge surge", fault, 0);
    dis = 1'b1; cyc((Q - 1) * DIV);
    dis = 1'b0; cyc(1);
    dis = 1'b1; cyc((Q - 1) * DIV);
    dis = 1'b0; cyc(2);
    chk("R3 split discharge surge", fault, 0);

    // R4: counts do not transfer between directions
    chg = 1'b1; cyc((Q - 1) * DIV);
    chg = 1'b0; dis = 1'b1; cyc((Q - 1) * DIV);
    dis = 1'b0; cyc(2);
    chk("R4 handover does not trip", fault, 0);

    // R4: simultaneous qualification reports charge
    surge(1'b1, 1'b1, Q * DIV);
    chk("R4 tie fault", fault, 1);
    chk("R4 tie reports charge", dir, 1);
    pulse_rise();

    // R5: discharge first
    dis = 1'b1; cyc(DIV);
    chg = 1'b1; cyc(Q * DIV);
    chg = 1'b0; dis = 1'b0; cyc(2);
    chk("R5 discharge first", dir, 2);
    pulse_rise();
    // R5: charge first
    chg = 1'b1; cyc(DIV);
    dis = 1'b1; cyc(Q * DIV);
    chg = 1'b0; dis = 1'b0; cyc(2);
    chk("R5 charge first", dir, 1);

    // R6: holds with no recovery event
    cyc(5 * DIV);
    chk("R6 fault held", fault, 1);
    chk("R6 dir held", dir, 1);
    chk("R6 bypass held", bypass_en, 1);

    // R8: high impedance recovery
    hiz = 1'b1; cyc(1);
    hiz = 1'b0; cyc(1);
    chk("R8 hiz clears fault", fault, 0);
    chk("R8 bypass off", bypass_en, 0);
    chk("R8 gate_off released", gate_off, 0);

    // R9: low enable drops bypass, hiz ignored, edge clears
    surge(1'b0, 1'b1, Q * DIV);
    chk("R9 tripped", fault, 1);
    en_lvl = 1'b0; cyc(2);
    chk("R9 bypass off with low enable", bypass_en, 0);
    chk("R9 fault kept", fault, 1);
    hiz = 1'b1; cyc(1);
    hiz = 1'b0; cyc(2);
    chk("R9 hiz ignored", fault, 1);
    chk("R9 dir kept", dir, 2);
    en_lvl = 1'b1;
    pulse_rise();
    chk("R7 edge clears held fault", fault, 0);
    chk("R7 dir cleared", dir, 0);
    chk("R7 gate_off released", gate_off, 0);

    // R10: low enable blocks trips and forces gate off
    en_lvl = 1'b0;
    surge(1'b1, 1'b1, (Q + 3) * DIV);
    chk("R10 no trip with low enable", fault, 0);
    chk("R10 gate_off with low enable", gate_off, 1);
    chk("R10 no bypass with low enable", bypass_en, 0);
    en_lvl = 1'b1; cyc(1);
    chk("R10 gate_off follows enable", gate_off, 0);

    // R11: full requalification after recovery with flag still high
    chg = 1'b1; cyc(Q * DIV + 2);
    chk("R11 tripped", fault, 1);
    en_rise = 1'b1; cyc(1);
    en_rise = 1'b0;
    cyc((Q - 1) * DIV);
    chk("R11 no early retrip", fault, 0);
    cyc(2 * DIV);
    chk("R11 retrip after full count", fault, 1);
    chg = 1'b0;
    pulse_rise();
    chk("R11 cleared at end", fault, 0);

    done = 1'b1;
    finish_run();
  end
endmodule